// File: doc/BRIEF.md
# Fan PWM Edge-Point Generator

This block drives one fan PWM pin from a shared base clock. A prescaler divides the clock by a power of two, chosen by a high divider field, and by a second factor taken from a low divider field. Each prescaled tick advances a period counter that runs from zero up to an 8-bit unit value and then wraps. A rise point and a fall point mark where the output goes high and low within each period.

Three clock profiles exist side by side. Each profile has its own divider fields and unit value. The port picks one profile with a 2-bit type code, which arrives as two separate control bits. The rise and fall points come from one half of a shared 32-bit duty word. A parameter decides which half belongs to this port.

Software converts a 0 to 255 duty request into an on-time before it writes the duty word. An on-time of zero disables the port. An on-time equal to the whole period is written as a fall point of zero. The counter shadows the unit, rise and fall values and picks up new ones only at a period boundary, so a write in the middle of a cycle never makes a runt pulse.

Top module: `fan_pwm_gen`

## Requirements
- R1: While rst_ni is low, and after reset until en_i is first seen high, pwm_o is low.
- R2: The prescale divisor is 2^H × (1 if L = 0, else 2×L), where H and L are the selected profile's high and low divider fields. Each counter value lasts that many clock cycles.
- R3: The period counter runs from 0 up to the shadowed unit value U and then returns to 0. The output pattern repeats every divisor × (U+1) cycles.
- R4: With rise = 0 and 0 < fall ≤ U, pwm_o is high for counter values 0 to fall−1 and low for the rest of the period.
- R5: A fall point of 0 holds pwm_o high for the whole time the port is enabled.
- R6: With rise < fall, pwm_o is high for counter values from rise to fall−1. With rise > fall (fall ≠ 0), it is high for values ≥ rise or < fall. With rise = fall ≠ 0, it stays low.
- R7: pwm_o goes low in the cycle after en_i is sampled low. On re-enable, the counter restarts at 0 and takes the current settings at once.
- R8: A change to the rise point, fall point or unit value while the port runs takes effect only at the next period boundary.
- R9: Parameter SLOT = 0 takes rise from duty bits 7:0 and fall from bits 15:8. SLOT = 1 takes rise from bits 23:16 and fall from bits 31:24. The other half has no effect.
- R10: The type code {type_hi_i, type_lo_i} selects profile 0, 1 or 2 for codes 0, 1 or 2. Code 3 selects profile 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Base clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Port enable |
| type_lo_i | input | 1 | Type code bit 0 |
| type_hi_i | input | 1 | Type code bit 1 |
| prof_div_h_i | input | 3×4 | High divider field for each profile |
| prof_div_l_i | input | 3×4 | Low divider field for each profile |
| prof_unit_i | input | 3×8 | Period unit value for each profile |
| duty_word_i | input | 32 | Shared duty word holding rise and fall points |
| pwm_o | output | 1 | Fan PWM output |

## Verification
The checker assumes that the divider fields of the selected profile stay stable while the port runs. The prescale compare is live, so a divider change in mid-count only stretches or shortens a single tick. It places no limits on the rise, fall or unit inputs, because these pass through the shadow registers. The stimulus changes divider fields and the type code only while en_i is low, and holds en_i low for two cycles before every new setting. The duty word is the only input written while the port is running.

// File: rtl/fpwm_pkg.sv
package fpwm_pkg;
  localparam int DIV_H_W = 4;
  localparam int DIV_L_W = 4;
  localparam int UNIT_W  = 8;
  localparam int DUTY_W  = 4 * UNIT_W;
  localparam int TYPE_W  = 2;

  typedef struct packed {
    logic [DIV_H_W-1:0] div_h;
    logic [DIV_L_W-1:0] div_l;
    logic [UNIT_W-1:0]  unit;
  } prof_t;
endpackage

// File: rtl/fpwm_prescale.sv
module fpwm_prescale #(
  parameter int H_W = 4,
  parameter int L_W = 4
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           run_i,
  input  logic [H_W-1:0] div_h_i,
  input  logic [L_W-1:0] div_l_i,
  output logic           tick_o
);
  localparam int CNT_W = (1 << H_W) + L_W + 1;

  logic [CNT_W-1:0] base, div, pre_q;

  always_comb begin
    if (div_l_i == '0) base = CNT_W'(1);
    else               base = CNT_W'({div_l_i, 1'b0});
    div = base << div_h_i;
  end

  // >= keeps the count bounded if the divisor shrinks mid-count
  assign tick_o = run_i && (pre_q >= div - CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                pre_q <= '0;
    else if (!run_i || tick_o)  pre_q <= '0;
    else                        pre_q <= pre_q + CNT_W'(1);
  end
endmodule

// File: rtl/fpwm_window.sv
module fpwm_window #(
  parameter int U_W = 8
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           run_i,
  input  logic           tick_i,
  input  logic [U_W-1:0] unit_i,
  input  logic [U_W-1:0] rise_i,
  input  logic [U_W-1:0] fall_i,
  output logic [U_W-1:0] cnt_o,
  output logic [U_W-1:0] unit_o,
  output logic [U_W-1:0] fall_o,
  output logic           level_o
);
  logic [U_W-1:0] cnt_q, unit_q, rise_q, fall_q;
  logic           wrap;

  assign wrap = tick_i && (cnt_q >= unit_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      unit_q <= '0;
      rise_q <= '0;
      fall_q <= '0;
    end else if (!run_i || wrap) begin
      cnt_q  <= '0;
      unit_q <= unit_i;
      rise_q <= rise_i;
      fall_q <= fall_i;
    end else if (tick_i) begin
      cnt_q  <= cnt_q + U_W'(1);
    end
  end

  always_comb begin
    if (fall_q == '0)         level_o = 1'b1;
    else if (rise_q < fall_q) level_o = (cnt_q >= rise_q) && (cnt_q < fall_q);
    else if (rise_q > fall_q) level_o = (cnt_q >= rise_q) || (cnt_q < fall_q);
    else                      level_o = 1'b0;
  end

  assign cnt_o  = cnt_q;
  assign unit_o = unit_q;
  assign fall_o = fall_q;
endmodule

// File: rtl/fan_pwm_gen.sv
module fan_pwm_gen
  import fpwm_pkg::*;
#(
  parameter int NUM_PROF = 3,
  parameter int SLOT     = 0,
  parameter int H_W      = DIV_H_W,
  parameter int L_W      = DIV_L_W,
  parameter int U_W      = UNIT_W
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         en_i,
  input  logic                         type_lo_i,
  input  logic                         type_hi_i,
  input  logic [NUM_PROF-1:0][H_W-1:0] prof_div_h_i,
  input  logic [NUM_PROF-1:0][L_W-1:0] prof_div_l_i,
  input  logic [NUM_PROF-1:0][U_W-1:0] prof_unit_i,
  input  logic [4*U_W-1:0]             duty_word_i,
  output logic                         pwm_o
);
  localparam int HALF_W = 2 * U_W;

  logic [TYPE_W-1:0] code, sel;
  logic [H_W-1:0]    div_h;
  logic [L_W-1:0]    div_l;
  logic [U_W-1:0]    unit_sel, rise_w, fall_w;
  logic [U_W-1:0]    cnt, unit_act, fall_act;
  logic              en_q, tick, level;

  assign code = {type_hi_i, type_lo_i};
  assign sel  = (32'(code) < 32'(NUM_PROF)) ? code : '0;

  assign div_h    = prof_div_h_i[sel];
  assign div_l    = prof_div_l_i[sel];
  assign unit_sel = prof_unit_i[sel];

  generate
    if (SLOT == 0) begin : g_slot_lo
      assign rise_w = duty_word_i[U_W-1:0];
      assign fall_w = duty_word_i[HALF_W-1:U_W];
      logic unused_half;
      assign unused_half = ^duty_word_i[4*U_W-1:HALF_W];
    end else begin : g_slot_hi
      assign rise_w = duty_word_i[HALF_W+U_W-1:HALF_W];
      assign fall_w = duty_word_i[4*U_W-1:HALF_W+U_W];
      logic unused_half;
      assign unused_half = ^duty_word_i[HALF_W-1:0];
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) en_q <= 1'b0;
    else         en_q <= en_i;
  end

  fpwm_prescale #(.H_W(H_W), .L_W(L_W)) u_pre (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .run_i   (en_q),
    .div_h_i (div_h),
    .div_l_i (div_l),
    .tick_o  (tick)
  );

  fpwm_window #(.U_W(U_W)) u_win (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .run_i   (en_q),
    .tick_i  (tick),
    .unit_i  (unit_sel),
    .rise_i  (rise_w),
    .fall_i  (fall_w),
    .cnt_o   (cnt),
    .unit_o  (unit_act),
    .fall_o  (fall_act),
    .level_o (level)
  );

  assign pwm_o = en_q & level;
endmodule

// File: rtl/fan_pwm_gen_chk.sv
module fan_pwm_gen_chk #(
  parameter int U_W = 8
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           en_i,
  input logic           en_q,
  input logic           tick,
  input logic [U_W-1:0] cnt,
  input logic [U_W-1:0] unit_act,
  input logic [U_W-1:0] fall_act,
  input logic           pwm_o
);
  p_off_when_disabled_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !pwm_o);

  p_restart_at_zero_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_q |=> cnt == '0);

  p_cnt_in_range_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_q |-> cnt <= unit_act);

  p_full_on_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_q && fall_act == '0) |-> pwm_o);

  p_cnt_holds_between_ticks_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_q && en_i && !tick) |=> $stable(cnt));

  p_shadow_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_q && en_i && !(tick && cnt == unit_act)) |=> ($stable(fall_act) && $stable(unit_act)));
endmodule

bind fan_pwm_gen fan_pwm_gen_chk #(.U_W(U_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .en_i     (en_i),
  .en_q     (en_q),
  .tick     (tick),
  .cnt      (cnt),
  .unit_act (unit_act),
  .fall_act (fall_act),
  .pwm_o    (pwm_o)
);

// File: tb/fan_pwm_gen_test.sv
`timescale 1ns/1ps
module fan_pwm_gen_test;
  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic             en_i = 1'b0;
  logic             type_lo_i = 1'b0;
  logic             type_hi_i = 1'b0;
  logic [2:0][3:0]  prof_div_h_i = '0;
  logic [2:0][3:0]  prof_div_l_i = '0;
  logic [2:0][7:0]  prof_unit_i = '0;
  logic [31:0]      duty_word_i = '0;
  logic             pwm_o, pwm_hi;

  int n_checks = 0;
  int n_err    = 0;

  always #10 clk_i = ~clk_i;

  fan_pwm_gen #(.SLOT(0)) uut (
    .clk_i, .rst_ni, .en_i, .type_lo_i, .type_hi_i,
    .prof_div_h_i, .prof_div_l_i, .prof_unit_i, .duty_word_i, .pwm_o(pwm_o)
  );

  fan_pwm_gen #(.SLOT(1)) uut_hi (
    .clk_i, .rst_ni, .en_i, .type_lo_i, .type_hi_i,
    .prof_div_h_i, .prof_div_l_i, .prof_unit_i, .duty_word_i, .pwm_o(pwm_hi)
  );

  // {code[25:24], request[23:16], div_h[15:12], div_l[11:8], unit[7:0]}
  localparam logic [25:0] VECS [8] = '{
    {2'd0, 8'd255, 4'd0, 4'd0, 8'd9},
    {2'd0, 8'd128, 4'd0, 4'd0, 8'd9},
    {2'd1, 8'd100, 4'd1, 4'd2, 8'd5},
    {2'd2, 8'd200, 4'd0, 4'd3, 8'd7},
    {2'd3, 8'd120, 4'd2, 4'd0, 8'd4},
    {2'd1, 8'd10,  4'd0, 4'd0, 8'd20},
    {2'd2, 8'd254, 4'd0, 4'd5, 8'd3},
    {2'd0, 8'd30,  4'd3, 4'd1, 8'd15}
  };

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int divisor(input int h, input int l);
    return (1 << h) * ((l == 0) ? 1 : 2 * l);
  endfunction

  // load one profile with the settings, others with decoys; restart port
  task automatic apply(input int code, input int h, input int l, input int unit,
                       input int rise, input int fall, input int upper, input bit en);
    int p;
    @(negedge clk_i);
    en_i = 1'b0;
    p = (code == 3) ? 0 : code;
    for (int i = 0; i < 3; i++) begin
      prof_div_h_i[i] = 4'd1;
      prof_div_l_i[i] = 4'd1;
      prof_unit_i[i]  = 8'd3;
    end
    prof_div_h_i[p] = 4'(h);
    prof_div_l_i[p] = 4'(l);
    prof_unit_i[p]  = 8'(unit);
    {type_hi_i, type_lo_i} = 2'(code);
    duty_word_i = {16'(upper), 8'(fall), 8'(rise)};
    @(negedge clk_i);
    @(negedge clk_i);
    en_i = en;
  endtask

  task automatic measure(input int n, output int highs, output int first_high,
                         output int first_low, output int hi_highs);
    highs = 0; hi_highs = 0; first_high = n; first_low = n;
    for (int k = 0; k < n; k++) begin
      @(negedge clk_i);
      if (pwm_o) begin
        highs++;
        if (first_high == n) first_high = k;
      end else if (first_low == n) first_low = k;
      if (pwm_hi) hi_highs++;
    end
  endtask

  initial begin
    #3000000;
    n_checks++;
    n_err++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end

  initial begin
    int hs, fh, fl, hh;
    // R1: reset holds output low even with enable and full-on settings
    en_i = 1'b1;
    prof_unit_i[0] = 8'd9;
    repeat (3) @(negedge clk_i);
    check(pwm_o == 1'b0, "R1 output during reset", int'(pwm_o), 0);
    en_i = 1'b0;
    rst_ni = 1'b1;
    @(negedge clk_i);
    check(pwm_o == 1'b0 && pwm_hi == 1'b0, "R1 output after reset", int'(pwm_o), 0);

    // table walk: request conversion done here, then two periods measured
    foreach (VECS[v]) begin
      int code, req, h, l, unit, d, per, on, fall, exp_hi, exp_fl;
      code = int'(VECS[v][25:24]);
      req  = int'(VECS[v][23:16]);
      h    = int'(VECS[v][15:12]);
      l    = int'(VECS[v][11:8]);
      unit = int'(VECS[v][7:0]);
      d    = divisor(h, l);
      per  = d * (unit + 1);
      on   = req * (unit + 1) / 255;
      fall = (on == unit + 1) ? 0 : on;
      exp_hi = (on == 0) ? 0 : ((fall == 0) ? per : on * d);
      exp_fl = (on == 0) ? 0 : ((fall == 0) ? per : on * d);
      apply(code, h, l, unit, 0, fall, 0, on != 0);
      measure(per, hs, fh, fl, hh);
      check(hs == exp_hi, $sformatf("R3 R10 vec%0d high cycles", v), hs, exp_hi);
      check(fl == exp_fl, $sformatf("R2 R4 vec%0d first low", v), fl, exp_fl);
      measure(per, hs, fh, fl, hh);
      check(hs == exp_hi, $sformatf("R3 vec%0d second period", v), hs, exp_hi);
    end

    // R5: fall point zero stays high over several periods
    apply(0, 0, 0, 9, 4, 0, 0, 1'b1);
    measure(30, hs, fh, fl, hh);
    check(hs == 30, "R5 fall zero always on", hs, 30);

    // R6: window, wrapped window, equal points
    apply(0, 0, 0, 9, 3, 7, 0, 1'b1);
    measure(10, hs, fh, fl, hh);
    check(hs == 4, "R6 window high count", hs, 4);
    check(fh == 3, "R6 window rise index", fh, 3);
    apply(0, 0, 0, 9, 7, 3, 0, 1'b1);
    measure(10, hs, fh, fl, hh);
    check(hs == 6, "R6 wrapped high count", hs, 6);
    check(fl == 3, "R6 wrapped fall index", fl, 3);
    apply(0, 0, 0, 9, 5, 5, 0, 1'b1);
    measure(10, hs, fh, fl, hh);
    check(hs == 0, "R6 equal points low", hs, 0);

    // R9: slot selection, other half ignored
    apply(0, 0, 0, 9, 0, 3, 16'h0000, 1'b1);
    measure(10, hs, fh, fl, hh);
    check(hs == 3, "R9 slot0 lower half", hs, 3);
    check(hh == 10, "R9 slot1 upper half", hh, 10);
    apply(0, 0, 0, 9, 0, 0, 16'h0602, 1'b1);
    measure(10, hs, fh, fl, hh);
    check(hs == 10, "R9 slot0 ignores upper", hs, 10);
    check(hh == 4, "R9 slot1 rise2 fall6", hh, 4);

    // R7: disable drops output next cycle; re-enable restarts at zero
    apply(0, 0, 0, 9, 0, 0, 0, 1'b1);
    repeat (4) @(negedge clk_i);
    en_i = 1'b0;
    @(negedge clk_i);
    check(pwm_o == 1'b0, "R7 low after disable", int'(pwm_o), 0);
    duty_word_i = {16'h0, 8'd2, 8'd0};
    en_i = 1'b1;
    measure(10, hs, fh, fl, hh);
    check(fl == 2 && hs == 2, "R7 restart at count zero", fl, 2);

    // R8: fall change mid-period applies at next boundary
    apply(0, 0, 0, 9, 0, 4, 0, 1'b1);
    hs = 0;
    for (int k = 0; k < 10; k++) begin
      @(negedge clk_i);
      if (pwm_o) hs++;
      if (k == 1) duty_word_i = {16'h0, 8'd8, 8'd0};
    end
    check(hs == 4, "R8 old fall kept in period", hs, 4);
    measure(10, hs, fh, fl, hh);
    check(hs == 8, "R8 new fall next period", hs, 8);

    en_i = 1'b0;
    @(negedge clk_i);
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end
endmodule